// File: doc/BRIEF.md
# Chopper Polarity Multiplexer Sequencer

This block paces an ADC input multiplexer through its measurement cycles and chooses the chopper polarity for each cycle. Every cycle is `NUM_SLOTS` slots long, and each slot is advanced by one `tick` strobe. The block groups a programmable number of regular cycles into an accumulation interval. It reports the end of each cycle and the end of each interval through two busy flags. Firmware treats the falling edge of each flag as an interrupt.

Firmware can ask for an alternate cycle, such as a die temperature reading. That cycle is spliced in at the next cycle boundary and does not count toward the interval. Polarity either alternates on its own, or is forced through a 2-bit field on the first cycle after each interval end. If firmware flips that field every interval, the offset on the alternate reading cancels out.

The sequencer is idle after reset. A `tick` while idle starts a cycle. `NUM_SLOTS` further ticks run the cycle to its end, and the sequencer is idle again. That idle tick is the boundary where the inputs are sampled. Polarity encoding: 0 means positive, 1 means reversed.

Top module: `chop_pol_mux_seq`

## Requirements
- R1: After reset the slot output is 0, polarity is positive (0), the alternate indicator is low and both busy flags are low.
- R2: A tick while idle starts a cycle: `cycle_busy` rises and the slot is 0. Each further tick advances the slot by one up to `NUM_SLOTS-1`. The next tick ends the cycle, and `cycle_busy` falls with the slot back at 0.
- R3: When `chop_en` is 2'b00 or 2'b11 (automatic), each regular cycle takes the opposite polarity of the previous regular cycle. The first regular cycle after reset is positive.
- R4: `xfer_busy` rises when a regular cycle starts. It falls on the same clock as `cycle_busy` at the end of the n-th regular cycle of the interval, and the count then restarts at cycle 1.
- R5: The cycles-per-interval input is captured when the first regular cycle of an interval starts, so a later change only takes effect from the next interval. A value of 0 acts as 1.
- R6: A pulse on `alt_req` leaves a request pending. The next cycle to start is an alternate cycle: `alt_active` is high for that cycle, the cycle is not counted toward the interval, and `xfer_busy` does not change at its start or end. The request is consumed when that cycle begins.
- R7: In automatic mode an alternate cycle runs with positive polarity. It does not disturb the alternation of the regular cycles around it.
- R8: With `chop_en` 2'b10 the first cycle after reset or after an interval end is forced positive; with 2'b01 it is forced reversed. This applies whether that cycle is regular or alternate. Later cycles in the interval use automatic alternation, continuing from the last regular polarity.
- R9: Polarity stays constant for a whole cycle. Changes to `chop_en` or `alt_req` made during a cycle only take effect at the next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slot-advance strobe, one clock wide |
| cycles_per_int | input | CNT_W | Regular cycles per accumulation interval (0 acts as 1) |
| chop_en | input | 2 | 2'b10 forced positive, 2'b01 forced reversed, else automatic |
| alt_req | input | 1 | Request pulse for one alternate cycle |
| mux_slot | output | SLOT_W | Current multiplexer slot |
| chop_pol | output | 1 | Chopper polarity: 0 positive, 1 reversed |
| alt_active | output | 1 | High during an alternate cycle |
| cycle_busy | output | 1 | High during a cycle; falling edge marks cycle end |
| xfer_busy | output | 1 | High during an interval; falling edge marks interval end |

## Verification
Each test targets a cycle boundary where a sequencer can get the order wrong, with an expected outcome for each.

- An alternate cycle wedged between regular cycles checks the interval count. A design that counts that cycle would drop `xfer_busy` one cycle early, and one that toggles polarity on it would break the regular alternation.
- A forced `chop_en` value is applied both to a regular and to an alternate first cycle, then changed mid-interval. A design that applies the field on every cycle, or that reads it mid-cycle, shows the wrong polarity on the following cycle.
- A zero interval length and an interval length changed mid-interval check when the count is captured. A design that reads the count live ends the interval at the wrong cycle.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_REV = 1'b1
    } pol_e;

    localparam logic [1:0] CHOP_FORCE_POS = 2'b10;
    localparam logic [1:0] CHOP_FORCE_REV = 2'b01;

    function automatic logic chop_is_forced(input logic [1:0] code);
        return (code == CHOP_FORCE_POS) || (code == CHOP_FORCE_REV);
    endfunction

endpackage

// File: rtl/cps_slot_timer.sv
module cps_slot_timer #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic              active,
    output logic [SLOT_W-1:0] slot,
    output logic              cyc_start,
    output logic              cyc_end
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
    } timer_t;

    timer_t st_d, st_q;

    assign cyc_start = tick && !st_q.active;
    assign cyc_end   = tick && st_q.active && (st_q.slot == LAST_SLOT);

    always_comb begin
        st_d = st_q;
        if (cyc_start) begin
            st_d.active = 1'b1;
            st_d.slot   = '0;
        end else if (cyc_end) begin
            st_d.active = 1'b0;
            st_d.slot   = '0;
        end else if (tick && st_q.active) begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign slot   = st_q.slot;

    p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST_SLOT);
    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && active && slot != LAST_SLOT) |=> (active && slot == $past(slot) + 1'b1));
    p_end_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (!active && slot == '0));
    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !active) |=> !active);

endmodule

// File: rtl/cps_interval_ctrl.sv
module cps_interval_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_end,
    input  logic             alt_req,
    input  logic [CNT_W-1:0] cycles_per_int,
    output logic             take_alt,
    output logic             first_cycle,
    output logic             alt_active,
    output logic             xfer_busy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             pend;
        logic             alt;
        logic             xfer;
        logic             first;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] n_lat;
    } ictl_t;

    ictl_t st_d, st_q;

    assign take_alt = cyc_start && st_q.pend;

    always_comb begin
        st_d = st_q;
        if (cyc_start) begin
            st_d.first = 1'b0;
            if (st_q.pend) begin
                st_d.alt  = 1'b1;
                st_d.pend = 1'b0;
            end else begin
                st_d.alt  = 1'b0;
                st_d.xfer = 1'b1;
                if (st_q.idx == ONE)
                    st_d.n_lat = (cycles_per_int == '0) ? ONE : cycles_per_int;
            end
        end else if (cyc_end) begin
            if (st_q.alt) begin
                st_d.alt = 1'b0;
            end else if (st_q.idx >= st_q.n_lat) begin
                st_d.idx   = ONE;
                st_d.xfer  = 1'b0;
                st_d.first = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
        if (alt_req) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
            st_q.idx   <= ONE;
            st_q.n_lat <= ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign first_cycle = st_q.first;
    assign alt_active  = st_q.alt;
    assign xfer_busy   = st_q.xfer;

    p_n_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.n_lat != '0);
    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx >= ONE) && (st_q.idx <= st_q.n_lat));
    p_alt_start_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_alt |=> ($stable(xfer_busy) && alt_active));
    p_alt_end_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && alt_active) |=> ($stable(xfer_busy) && !alt_active));
    p_reg_start_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !take_alt) |=> (xfer_busy && !alt_active));

endmodule

// File: rtl/cps_polarity.sv
module cps_polarity
    import cps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       take_alt,
    input  logic       first_cycle,
    input  logic [1:0] chop_en,
    output logic       pol
);
    typedef struct packed {
        pol_e pol;
        pol_e last_reg;
    } polst_t;

    polst_t st_d, st_q;
    logic   forced;
    pol_e   forced_pol;

    assign forced     = first_cycle && chop_is_forced(chop_en);
    assign forced_pol = (chop_en == CHOP_FORCE_REV) ? POL_REV : POL_POS;

    always_comb begin
        st_d = st_q;
        if (cyc_start) begin
            if (forced) begin
                st_d.pol = forced_pol;
                if (!take_alt) st_d.last_reg = forced_pol;
            end else if (take_alt) begin
                st_d.pol = POL_POS;
            end else begin
                st_d.pol      = (st_q.last_reg == POL_POS) ? POL_REV : POL_POS;
                st_d.last_reg = st_d.pol;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pol      <= POL_POS;
            st_q.last_reg <= POL_REV;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol = st_q.pol;

    p_pol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(pol));
    p_alt_auto_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && take_alt && !chop_is_forced(chop_en)) |=> (pol == POL_POS));
    p_force_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && first_cycle && chop_en == CHOP_FORCE_POS) |=> (pol == POL_POS));
    p_force_rev_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && first_cycle && chop_en == CHOP_FORCE_REV) |=> (pol == POL_REV));

endmodule

// File: rtl/chop_pol_mux_seq.sv
module chop_pol_mux_seq #(
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 4,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cycles_per_int,
    input  logic [1:0]        chop_en,
    input  logic              alt_req,
    output logic [SLOT_W-1:0] mux_slot,
    output logic              chop_pol,
    output logic              alt_active,
    output logic              cycle_busy,
    output logic              xfer_busy
);
    logic cyc_start, cyc_end, take_alt, first_cycle;

    cps_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .active    (cycle_busy),
        .slot      (mux_slot),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end)
    );

    cps_interval_ctrl #(.CNT_W(CNT_W)) u_ictl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cyc_start      (cyc_start),
        .cyc_end        (cyc_end),
        .alt_req        (alt_req),
        .cycles_per_int (cycles_per_int),
        .take_alt       (take_alt),
        .first_cycle    (first_cycle),
        .alt_active     (alt_active),
        .xfer_busy      (xfer_busy)
    );

    cps_polarity u_pol (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .take_alt    (take_alt),
        .first_cycle (first_cycle),
        .chop_en     (chop_en),
        .pol         (chop_pol)
    );

    p_xfer_fall_with_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_busy) |-> $fell(cycle_busy));
    p_alt_inside_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alt_active |-> cycle_busy);

endmodule

// File: tb/chop_pol_mux_seq_bench.sv
module chop_pol_mux_seq_bench;
    localparam int NS = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] cycles_per_int = CW'(1);
    logic [1:0]    chop_en = 2'b00;
    logic          alt_req = 1'b0;
    logic [1:0]    mux_slot;
    logic          chop_pol, alt_active, cycle_busy, xfer_busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    chop_pol_mux_seq #(.NUM_SLOTS(NS), .CNT_W(CW)) u_chop_pol_mux_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cycles_per_int(cycles_per_int),
        .chop_en(chop_en), .alt_req(alt_req), .mux_slot(mux_slot),
        .chop_pol(chop_pol), .alt_active(alt_active),
        .cycle_busy(cycle_busy), .xfer_busy(xfer_busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; alt_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_alt();
        alt_req = 1'b1;
        @(negedge clk);
        alt_req = 1'b0;
    endtask

    // One full cycle: start tick, NS-1 slot ticks, ending tick.
    task automatic do_cycle(input logic alt_mid, output logic pol, output logic alt,
                            output logic xin, output logic xout);
        pulse_tick();
        pol = chop_pol; alt = alt_active; xin = xfer_busy;
        chk("R2", "busy at start", int'(cycle_busy), 1);
        chk("R2", "slot at start", int'(mux_slot), 0);
        if (alt_mid) pulse_alt();
        for (int i = 1; i < NS; i++) begin
            pulse_tick();
            chk("R2", "slot step", int'(mux_slot), i);
            chk("R9", "pol held", int'(chop_pol), int'(pol));
            chk("R9", "alt held", int'(alt_active), int'(alt));
        end
        pulse_tick();
        chk("R2", "busy after end", int'(cycle_busy), 0);
        chk("R2", "slot after end", int'(mux_slot), 0);
        xout = xfer_busy;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "slot", int'(mux_slot), 0);
        chk("R1", "pol", int'(chop_pol), 0);
        chk("R1", "alt", int'(alt_active), 0);
        chk("R1", "cycle_busy", int'(cycle_busy), 0);
        chk("R1", "xfer_busy", int'(xfer_busy), 0);
    endtask

    task automatic t_auto_interval();
        logic p, a, xi, xo;
        cycles_per_int = CW'(3); chop_en = 2'b00;
        do_reset();
        do_cycle(1'b0, p, a, xi, xo);
        chk("R3", "c1 pol", int'(p), 0); chk("R4", "c1 xin", int'(xi), 1); chk("R4", "c1 xout", int'(xo), 1);
        chop_en = 2'b11;
        do_cycle(1'b0, p, a, xi, xo);
        chk("R3", "c2 pol", int'(p), 1); chk("R4", "c2 xout", int'(xo), 1);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R3", "c3 pol", int'(p), 0); chk("R4", "c3 xout", int'(xo), 0);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R3", "c4 pol", int'(p), 1); chk("R4", "c4 xin", int'(xi), 1);
    endtask

    task automatic t_count_capture();
        logic p, a, xi, xo;
        cycles_per_int = '0; chop_en = 2'b00;
        do_reset();
        do_cycle(1'b0, p, a, xi, xo);
        chk("R5", "n0 c1 xout", int'(xo), 0);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R5", "n0 c2 xout", int'(xo), 0);
        cycles_per_int = CW'(3);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R5", "n3 c1 xout", int'(xo), 1);
        cycles_per_int = CW'(1);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R5", "late change c2 xout", int'(xo), 1);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R5", "late change c3 xout", int'(xo), 0);
    endtask

    task automatic t_alt_auto();
        logic p, a, xi, xo;
        cycles_per_int = CW'(2); chop_en = 2'b00;
        do_reset();
        do_cycle(1'b1, p, a, xi, xo);
        chk("R9", "req mid-cycle alt", int'(a), 0); chk("R3", "A pol", int'(p), 0);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R6", "B alt", int'(a), 1); chk("R7", "B pol", int'(p), 0);
        chk("R6", "B xin", int'(xi), 1); chk("R6", "B xout", int'(xo), 1);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R6", "C alt", int'(a), 0); chk("R7", "C pol", int'(p), 1);
        chk("R6", "C xout", int'(xo), 0);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R6", "D consumed", int'(a), 0); chk("R7", "D pol", int'(p), 0);
    endtask

    task automatic t_forced();
        logic p, a, xi, xo;
        cycles_per_int = CW'(2); chop_en = 2'b01;
        do_reset();
        do_cycle(1'b0, p, a, xi, xo);
        chk("R8", "f1 forced rev", int'(p), 1);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R8", "f2 auto", int'(p), 0); chk("R4", "f2 xout", int'(xo), 0);
        pulse_tick();
        chk("R8", "f3 forced rev", int'(chop_pol), 1);
        chop_en = 2'b10;
        for (int i = 0; i < NS; i++) pulse_tick();
        chk("R9", "f3 kept rev", int'(chop_pol), 1);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R8", "f4 auto toggle", int'(p), 0); chk("R4", "f4 xout", int'(xo), 0);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R8", "f5 forced pos", int'(p), 0);
    endtask

    task automatic t_forced_alt();
        logic p, a, xi, xo;
        cycles_per_int = CW'(1); chop_en = 2'b01;
        do_reset();
        pulse_alt();
        do_cycle(1'b0, p, a, xi, xo);
        chk("R8", "alt forced rev", int'(p), 1); chk("R6", "alt flag", int'(a), 1);
        chk("R6", "alt xin", int'(xi), 0); chk("R6", "alt xout", int'(xo), 0);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R8", "next reg auto", int'(p), 0); chk("R4", "reg xin", int'(xi), 1);
        chk("R4", "reg xout", int'(xo), 0);
        do_cycle(1'b0, p, a, xi, xo);
        chk("R8", "new interval forced", int'(p), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_auto_interval();
        t_count_capture();
        t_alt_auto();
        t_forced();
        t_forced_alt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule